// File: doc/BRIEF.md
# Time-Tag Counter with Bus Synchronization

This block keeps a free-running time stamp for a serial-bus remote terminal. A 32-bit counter advances at a rate chosen by a 3-bit resolution code. The code picks a power-of-two number of 1 MHz ticks per count, from 1 µs to 64 µs. The top code hands the count over to an external clock-enable input, or halts the count when that option is left out at build time.

Two synchronize commands from the bus side can change the count. Each is gated by its own enable. A "sync with data" command overwrites the lower 16 bits with the command's data word. A strict compliance mode allows that load only when the data word's least significant bit is 0. A "sync without data" command clears the whole counter.

For the host, a holding register provides a single counter sample. That sample stays steady while it is read in pieces. A lock select chooses which read refreshes it: a read of the control register, which suits byte-wide access, or a read of the counter's lower word.

Top module: `time_tag_counter`

## Requirements
- R1: While `rst_n` is low, and on its release, `cnt_o` and `snap_o` are zero.
- R2: For `res_sel` = c with c in 0..6, `cnt_o` rises by one on every 2^c-th clock cycle in which `tick_1us` is high. A carry out of the lower 16 bits reaches the upper bits.
- R3: For `res_sel` = 7 with EXT_EN = 1, `cnt_o` rises by one on each cycle in which `ext_tick` is high, and `tick_1us` has no effect.
- R4: Any change of `res_sel` clears the prescaler. After the change, a full new period of ticks is needed before the next increment.
- R5: With `sync_rst_en` = 1, a cycle with `sync_nd_valid` high sets `cnt_o` to zero on the next edge. With `sync_rst_en` = 0 it has no effect.
- R6: With `sync_data_en` = 1, a cycle with `sync_wd_valid` high loads `sync_wd_data` into `cnt_o[15:0]` and leaves the upper bits unchanged. With `sync_data_en` = 0 it has no effect.
- R7: With `strict_sync` = 1, the load of R6 happens only when `sync_wd_data[0]` is 0.
- R8: A load or a clear overrides an increment in the same cycle, and a clear overrides a load.
- R9: The counter wraps from all ones to zero.
- R10: With `lock_low` = 0, a cycle with `rd_ctl` high copies `cnt_o` into `snap_o` at the next edge, and `rd_low` does not refresh it.
- R11: With `lock_low` = 1, a cycle with `rd_low` high copies `cnt_o` into `snap_o` at the next edge, and `rd_ctl` does not refresh it.
- R12: Outside the refresh of R10 and R11, `snap_o` holds its value while the counter keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_1us | input | 1 | One-cycle pulse every microsecond |
| ext_tick | input | 1 | External count enable, used when res_sel is 7 |
| res_sel | input | 3 | Resolution code, period 2^code µs, 7 = external/stop |
| sync_data_en | input | 1 | Enable for the lower-half load by sync with data |
| sync_rst_en | input | 1 | Enable for the clear by sync without data |
| strict_sync | input | 1 | Load only when the data LSB is 0 |
| lock_low | input | 1 | 0: refresh on control read, 1: refresh on lower-word read |
| sync_wd_valid | input | 1 | Valid sync-with-data command, one cycle |
| sync_wd_data | input | 16 | Data word of that command |
| sync_nd_valid | input | 1 | Valid sync-without-data command, one cycle |
| rd_ctl | input | 1 | Host read of the control register, one cycle |
| rd_low | input | 1 | Host read of the lower counter word, one cycle |
| cnt_o | output | 32 | Live counter |
| snap_o | output | 32 | Host holding register |

## Verification
The hardest state to reach from the ports is the wrap from all ones to zero, which would take billions of ticks at full width. The bench therefore adds a second 16-bit instance whose whole count can be loaded with 0xFFFF through the sync-with-data command. One further tick then shows the wrap. The same tick shows the 32-bit instance carrying into its upper half. A second hard case is a resolution change that leaves the prescaler partly filled. The bench drives exactly three quarters of a period, switches codes, and counts the ticks needed for the next increment.

// File: rtl/time_tag_counter.sv
module time_tag_counter #(
  parameter int CNT_W  = 32,
  parameter int LOAD_W = 16,
  parameter int RES_W  = 3,
  parameter bit EXT_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1us,
  input  logic              ext_tick,
  input  logic [RES_W-1:0]  res_sel,
  input  logic              sync_data_en,
  input  logic              sync_rst_en,
  input  logic              strict_sync,
  input  logic              lock_low,
  input  logic              sync_wd_valid,
  input  logic [LOAD_W-1:0] sync_wd_data,
  input  logic              sync_nd_valid,
  input  logic              rd_ctl,
  input  logic              rd_low,
  output logic [CNT_W-1:0]  cnt_o,
  output logic [CNT_W-1:0]  snap_o
);

  localparam int STOP_CODE = (1 << RES_W) - 1;
  localparam int PRE_W     = STOP_CODE - 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt, cnt_loaded;
  logic [CNT_W-1:0] snap_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic [RES_W-1:0] res_q;
  logic res_chg, stopped, step, do_clr, do_load, snap_take;

  assign res_chg   = (res_sel != res_q);
  assign stopped   = (res_sel == RES_W'(STOP_CODE));
  assign pre_lim   = PRE_W'((32'd1 << res_sel) - 32'd1);
  assign step      = res_chg ? 1'b0 :
                     stopped ? (EXT_EN && ext_tick) :
                               (tick_1us && (pre_q == pre_lim));
  assign do_clr    = sync_nd_valid && sync_rst_en;
  assign do_load   = sync_wd_valid && sync_data_en && !(strict_sync && sync_wd_data[0]);
  assign snap_take = lock_low ? rd_low : rd_ctl;

  generate
    if (CNT_W > LOAD_W) begin : g_split
      assign cnt_loaded = {cnt_q[CNT_W-1:LOAD_W], sync_wd_data};
    end else begin : g_whole
      assign cnt_loaded = sync_wd_data[CNT_W-1:0];
    end
  endgenerate

  always_comb begin
    if (do_clr)       cnt_nxt = '0;
    else if (do_load) cnt_nxt = cnt_loaded;
    else if (step)    cnt_nxt = cnt_q + 1'b1;
    else              cnt_nxt = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      snap_q <= '0;
      pre_q  <= '0;
      res_q  <= '0;
    end else begin
      res_q <= res_sel;
      cnt_q <= cnt_nxt;
      if (res_chg || stopped)
        pre_q <= '0;
      else if (tick_1us)
        pre_q <= (pre_q == pre_lim) ? '0 : pre_q + 1'b1;
      if (snap_take)
        snap_q <= cnt_q;
    end
  end

  assign cnt_o  = cnt_q;
  assign snap_o = snap_q;

endmodule

// File: rtl/time_tag_counter_chk.sv
module time_tag_counter_chk #(
  parameter int CNT_W  = 32,
  parameter int LOAD_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sync_data_en,
  input logic              sync_rst_en,
  input logic              strict_sync,
  input logic              lock_low,
  input logic              sync_wd_valid,
  input logic [LOAD_W-1:0] sync_wd_data,
  input logic              sync_nd_valid,
  input logic              rd_ctl,
  input logic              rd_low,
  input logic [CNT_W-1:0]  cnt_o,
  input logic [CNT_W-1:0]  snap_o
);

  logic [CNT_W-1:0] cnt_inc;
  logic clr_req, load_req, any_sync;
  assign cnt_inc  = cnt_o + 1'b1;
  assign clr_req  = sync_nd_valid && sync_rst_en;
  assign load_req = sync_wd_valid && sync_data_en;
  assign any_sync = clr_req || load_req;

  p_reset_zero_r1: assert property (@(posedge clk)
    !rst_n |=> (cnt_o == '0 && snap_o == '0));

  p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !any_sync |=> (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_inc)));

  p_sync_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_req |=> cnt_o == '0);

  p_sync_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && !clr_req && !strict_sync) |=>
      cnt_o[LOAD_W-1:0] == $past(sync_wd_data));

  p_strict_skip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_req && strict_sync && sync_wd_data[0] && !clr_req) |=>
      (cnt_o == $past(cnt_o) || cnt_o == $past(cnt_inc)));

  p_snap_ctl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_low && rd_ctl) |=> snap_o == $past(cnt_o));

  p_snap_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_low && rd_low) |=> snap_o == $past(cnt_o));

  p_snap_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(lock_low ? rd_low : rd_ctl) |=> $stable(snap_o));

endmodule

bind time_tag_counter time_tag_counter_chk #(.CNT_W(CNT_W), .LOAD_W(LOAD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_data_en(sync_data_en), .sync_rst_en(sync_rst_en),
  .strict_sync(strict_sync), .lock_low(lock_low), .sync_wd_valid(sync_wd_valid),
  .sync_wd_data(sync_wd_data), .sync_nd_valid(sync_nd_valid), .rd_ctl(rd_ctl),
  .rd_low(rd_low), .cnt_o(cnt_o), .snap_o(snap_o)
);

// File: tb/time_tag_counter_tb.sv
module time_tag_counter_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1us = 0, ext_tick = 0;
  logic [2:0] res_sel = 3'd0;
  logic sync_data_en = 0, sync_rst_en = 0, strict_sync = 0, lock_low = 0;
  logic sync_wd_valid = 0, sync_nd_valid = 0, rd_ctl = 0, rd_low = 0;
  logic [15:0] sync_wd_data = '0;
  logic [31:0] cnt_o, snap_o;
  logic [15:0] cnt16, snap16;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  time_tag_counter u_dut (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .ext_tick(ext_tick), .res_sel(res_sel),
    .sync_data_en(sync_data_en), .sync_rst_en(sync_rst_en), .strict_sync(strict_sync),
    .lock_low(lock_low), .sync_wd_valid(sync_wd_valid), .sync_wd_data(sync_wd_data),
    .sync_nd_valid(sync_nd_valid), .rd_ctl(rd_ctl), .rd_low(rd_low),
    .cnt_o(cnt_o), .snap_o(snap_o));

  time_tag_counter #(.CNT_W(16)) u_dut16 (
    .clk(clk), .rst_n(rst_n), .tick_1us(tick_1us), .ext_tick(ext_tick), .res_sel(res_sel),
    .sync_data_en(sync_data_en), .sync_rst_en(sync_rst_en), .strict_sync(strict_sync),
    .lock_low(lock_low), .sync_wd_valid(sync_wd_valid), .sync_wd_data(sync_wd_data),
    .sync_nd_valid(sync_nd_valid), .rd_ctl(rd_ctl), .rd_low(rd_low),
    .cnt_o(cnt16), .snap_o(snap16));

  // {code, tick count, expected count}
  localparam logic [18:0] VEC [0:7] = '{
    {3'd0, 8'd5,   8'd5}, {3'd1, 8'd7,   8'd3}, {3'd2, 8'd9,  8'd2},
    {3'd3, 8'd20,  8'd2}, {3'd4, 8'd40,  8'd2}, {3'd5, 8'd70, 8'd2},
    {3'd6, 8'd130, 8'd2}, {3'd7, 8'd10,  8'd0}};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] code);
    @(negedge clk);
    rst_n = 0; res_sel = code;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick_1us = 1; @(negedge clk);
      tick_1us = 0; @(negedge clk);
    end
  endtask

  task automatic pulse_ext(input int n);
    for (int i = 0; i < n; i++) begin
      ext_tick = 1; @(negedge clk);
      ext_tick = 0; @(negedge clk);
    end
  endtask

  task automatic wd(input logic [15:0] d);
    sync_wd_valid = 1; sync_wd_data = d; @(negedge clk);
    sync_wd_valid = 0; @(negedge clk);
  endtask

  task automatic nd();
    sync_nd_valid = 1; @(negedge clk);
    sync_nd_valid = 0; @(negedge clk);
  endtask

  task automatic rd(input bit low);
    if (low) rd_low = 1; else rd_ctl = 1;
    @(negedge clk);
    rd_low = 0; rd_ctl = 0; @(negedge clk);
  endtask

  initial begin
    #(5ns * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(3'd0);
    check("R1 cnt", cnt_o, 0);
    check("R1 snap", snap_o, 0);

    for (int v = 0; v < 8; v++) begin
      do_reset(VEC[v][18:16]);
      ticks(int'(VEC[v][15:8]));
      check("R2 rate table", cnt_o, 32'(VEC[v][7:0]));
    end

    // R3: external source
    do_reset(3'd7);
    pulse_ext(4);
    check("R3 ext count", cnt_o, 4);
    ticks(3);
    check("R3 internal ignored", cnt_o, 4);

    // R4: prescaler cleared on code change
    do_reset(3'd2);
    ticks(3);
    res_sel = 3'd1; repeat (2) @(negedge clk);
    ticks(1);
    check("R4 no early step", cnt_o, 0);
    ticks(1);
    check("R4 full period", cnt_o, 1);

    // R5
    do_reset(3'd0);
    ticks(5);
    nd();
    check("R5 disabled", cnt_o, 5);
    sync_rst_en = 1; nd();
    check("R5 clear", cnt_o, 0);

    // R6
    wd(16'h1234);
    check("R6 disabled", cnt_o, 0);
    sync_data_en = 1; wd(16'h1234);
    check("R6 load", cnt_o, 32'h1234);

    // R7
    do_reset(3'd0);
    strict_sync = 1; wd(16'h0011);
    check("R7 odd blocked", cnt_o, 0);
    wd(16'h0010);
    check("R7 even loads", cnt_o, 32'h10);
    strict_sync = 0;

    // R8
    tick_1us = 1; sync_wd_valid = 1; sync_wd_data = 16'h0100; @(negedge clk);
    tick_1us = 0; sync_wd_valid = 0; @(negedge clk);
    check("R8 load over step", cnt_o, 32'h100);
    sync_wd_valid = 1; sync_nd_valid = 1; sync_wd_data = 16'h0055; @(negedge clk);
    sync_wd_valid = 0; sync_nd_valid = 0; @(negedge clk);
    check("R8 clear over load", cnt_o, 0);

    // R9 and R2 carry
    do_reset(3'd0);
    wd(16'hFFFF);
    ticks(1);
    check("R9 wrap", 32'(cnt16), 0);
    check("R2 carry", cnt_o, 32'h10000);

    // R10, R11, R12
    do_reset(3'd0);
    ticks(7);
    lock_low = 0; rd(1'b1);
    check("R10 low read ignored", snap_o, 0);
    rd(1'b0);
    check("R10 ctl refresh", snap_o, 7);
    ticks(2);
    check("R12 hold", snap_o, 7);
    lock_low = 1; rd(1'b0);
    check("R11 ctl read ignored", snap_o, 7);
    rd(1'b1);
    check("R11 low refresh", snap_o, 9);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule